// File: doc/BRIEF.md
# Bit-band alias bridge

This block is a bus slave that serves a 32 MB alias window in which each aligned alias word stands for a single bit of a 1 MB backing region. The bus fabric steers alias traffic to the slave port. The bridge then drives a master port toward the backing memory. The backing region's base address is a parameter, so a system that aliases two regions uses two instances. One instance would have backing base 0x2000_0000 aliased at 0x2200_0000, and the other backing base 0x4000_0000 aliased at 0x4200_0000.

**Alias read.** The bridge fetches the backing location and answers with the chosen bit alone, as 0 or 1.

**Alias write.** The bridge fetches the backing location and flips only the addressed bit to the value carried in write-data bit 0. It then stores the whole location back. The lock output stays high from the start of the fetch until the store completes, so no other master can come in between.

**Access sizes.** Byte, halfword and word sizes are supported. The size picks both the alignment of the backing address and how many offset bits form the bit number.

Top module: `bitalias_bridge`

## Requirements
- R1: After synchronous reset, `s_ready`, `m_req` and `m_lock` are low.
- R2: The backing address on `m_addr` is BASE ORed with (`s_addr[24:0]` shifted right by 5). Bits `s_addr[31:25]` have no effect. For a halfword access (size 1), `m_addr[0]` is forced to 0. For a word access (size 2), `m_addr[1:0]` are forced to 0. A byte access (size 0) keeps the address unchanged. `m_size` repeats the request size.
- R3: The bit number is taken from the alias address. A byte access uses `s_addr[4:2]`, a halfword access uses `s_addr[5:2]`, and a word access uses `s_addr[6:2]`. `s_addr[1:0]` have no effect.
- R4: The response to an alias read carries the selected backing bit in `s_rdata[0]`, and `s_rdata[31:1]` are zero.
- R5: An alias read causes exactly one backing read (`m_we` = 0), with `m_lock` low.
- R6: An alias write causes exactly one backing read followed by exactly one backing write, both to the same address and at the same size. The value written back equals the value read, except in the selected bit.
- R7: The new value of the selected bit is `s_wdata[0]`: 1 sets the bit and 0 clears it. `s_wdata[31:1]` have no effect on backing memory.
- R8: During an alias write, `m_lock` is high for both backing transfers. When the locked read completes, the write request follows in the very next cycle.
- R9: Backing data is little-endian and right-justified. Byte address A sits in `m_rdata[7:0]` and `m_wdata[7:0]`, A+1 sits in bits [15:8], and so on. Bits of `m_rdata` above the access size are ignored.
- R10: `s_ready` is a single-cycle pulse, raised only after the last backing transfer has been accepted. While `m_req` waits for `m_ready`, the request stays asserted with the same address and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_req | input | 1 | Alias request, held until `s_ready` |
| s_we | input | 1 | 1 = alias write, 0 = alias read |
| s_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| s_addr | input | 32 | Alias address |
| s_wdata | input | 32 | Alias write data; only bit 0 is used |
| s_ready | output | 1 | One-cycle completion pulse |
| s_rdata | output | 32 | Alias read result (0 or 1) |
| m_req | output | 1 | Backing request, held until `m_ready` |
| m_we | output | 1 | Backing write when high |
| m_lock | output | 1 | Keeps the backing fetch and store of an alias write together |
| m_size | output | 2 | Backing access size |
| m_addr | output | 32 | Backing byte address |
| m_wdata | output | 32 | Backing write data, right-justified |
| m_ready | input | 1 | Backing transfer accepted; read data valid |
| m_rdata | input | 32 | Backing read data, right-justified |

## Verification
The assertions assume the following of the bridge's neighbours:
- The slave-side master holds `s_req` steady until it sees `s_ready`.
- The master uses only size codes 0 to 2.
- The backing memory raises `m_ready` for one cycle, and only while `m_req` is high.

The bench's memory responder keeps to these rules. It waits zero to two cycles before each `m_ready` pulse, and it always returns four bytes, so that neighbouring bytes appear above a narrow access. The bench drops `s_req` on the falling edge where it sees the response. The sweeps cover every bit of every size at several backing locations, with random upper alias bits, random low two bits and random write-data bits above bit 0.

// File: rtl/bitalias_pkg.sv
package bitalias_pkg;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int IDX_W      = $clog2(DATA_W);
    localparam int STRIDE_LSB = 2;   // alias words are four bytes apart
    localparam int BYTE_BITS  = 3;   // log2 of bits per byte

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD,
        ST_WR,
        ST_RESP
    } state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [IDX_W-1:0]  idx;
        size_e             size;
        logic              we;
        logic              val;
    } op_t;

    function automatic logic [DATA_W-1:0] lane_mask(size_e s);
        case (s)
            SZ_BYTE: lane_mask = DATA_W'(8'hFF);
            SZ_HALF: lane_mask = DATA_W'(16'hFFFF);
            default: lane_mask = '1;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] align_mask(size_e s);
        case (s)
            SZ_BYTE: align_mask = '1;
            SZ_HALF: align_mask = ~ADDR_W'(1);
            default: align_mask = ~ADDR_W'(3);
        endcase
    endfunction
endpackage

// File: rtl/bitalias_xlate.sv
module bitalias_xlate
    import bitalias_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE     = 32'h2000_0000,
    parameter int                WIN_BITS = 25
) (
    input  logic [ADDR_W-1:0] alias_addr,
    input  size_e             size,
    output logic [ADDR_W-1:0] back_addr,
    output logic [IDX_W-1:0]  bit_idx
);
    localparam int SHIFT = BYTE_BITS + STRIDE_LSB;

    logic [WIN_BITS-1:0] offs;
    logic [ADDR_W-1:0]   raw;
    logic                unused_hi;

    assign offs      = alias_addr[WIN_BITS-1:0];
    assign raw       = BASE | ADDR_W'(offs >> SHIFT);
    assign back_addr = raw & align_mask(size);
    assign unused_hi = ^alias_addr[ADDR_W-1:WIN_BITS];

    always_comb begin
        case (size)
            SZ_BYTE: bit_idx = IDX_W'(alias_addr[STRIDE_LSB +: BYTE_BITS]);
            SZ_HALF: bit_idx = IDX_W'(alias_addr[STRIDE_LSB +: BYTE_BITS+1]);
            default: bit_idx = alias_addr[STRIDE_LSB +: IDX_W];
        endcase
    end
endmodule

// File: rtl/bitalias_merge.sv
module bitalias_merge
    import bitalias_pkg::*;
(
    input  logic [DATA_W-1:0] rd_data,
    input  size_e             size,
    input  logic [IDX_W-1:0]  idx,
    input  logic              val,
    output logic              bit_out,
    output logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] lanes;

    assign lanes   = rd_data & lane_mask(size);
    assign bit_out = lanes[idx];

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign wr_data[i] = (idx == IDX_W'(i)) ? val : lanes[i];
    end
endmodule

// File: rtl/bitalias_seq.sv
module bitalias_seq
    import bitalias_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic s_req,
    input  logic op_we,
    input  logic m_ready,
    output logic cap_req,
    output logic cap_rd,
    output logic m_req,
    output logic m_we,
    output logic m_lock,
    output logic s_ready
);
    state_e state, nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: if (s_req)   nxt = ST_RD;
            ST_RD:   if (m_ready) nxt = op_we ? ST_WR : ST_RESP;
            ST_WR:   if (m_ready) nxt = ST_RESP;
            default:              nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    assign cap_req = (state == ST_IDLE) && s_req;
    assign cap_rd  = (state == ST_RD) && m_ready;
    assign m_req   = (state == ST_RD) || (state == ST_WR);
    assign m_we    = (state == ST_WR);
    assign m_lock  = ((state == ST_RD) && op_we) || (state == ST_WR);
    assign s_ready = (state == ST_RESP);
endmodule

// File: rtl/bitalias_bridge.sv
module bitalias_bridge
    import bitalias_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE     = 32'h2000_0000,
    parameter int                WIN_BITS = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_req,
    input  logic              s_we,
    input  logic [1:0]        s_size,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [DATA_W-1:0] s_wdata,
    output logic              s_ready,
    output logic [DATA_W-1:0] s_rdata,
    output logic              m_req,
    output logic              m_we,
    output logic              m_lock,
    output logic [1:0]        m_size,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_wdata,
    input  logic              m_ready,
    input  logic [DATA_W-1:0] m_rdata
);
    op_t               op_q;
    logic [ADDR_W-1:0] xl_addr;
    logic [IDX_W-1:0]  xl_idx;
    logic              cap_req, cap_rd, sel_bit;
    logic [DATA_W-1:0] merged, wbuf, rdat_q;
    logic              unused_wd;

    assign unused_wd = ^s_wdata[DATA_W-1:1];

    bitalias_xlate #(.BASE(BASE), .WIN_BITS(WIN_BITS)) u_xlate (
        .alias_addr (s_addr),
        .size       (size_e'(s_size)),
        .back_addr  (xl_addr),
        .bit_idx    (xl_idx)
    );

    bitalias_merge u_merge (
        .rd_data (m_rdata),
        .size    (op_q.size),
        .idx     (op_q.idx),
        .val     (op_q.val),
        .bit_out (sel_bit),
        .wr_data (merged)
    );

    bitalias_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .s_req   (s_req),
        .op_we   (op_q.we),
        .m_ready (m_ready),
        .cap_req (cap_req),
        .cap_rd  (cap_rd),
        .m_req   (m_req),
        .m_we    (m_we),
        .m_lock  (m_lock),
        .s_ready (s_ready)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= '0;
            wbuf   <= '0;
            rdat_q <= '0;
        end else begin
            if (cap_req) begin
                op_q.addr <= xl_addr;
                op_q.idx  <= xl_idx;
                op_q.size <= size_e'(s_size);
                op_q.we   <= s_we;
                op_q.val  <= s_wdata[0];
            end
            if (cap_rd) begin
                wbuf   <= merged;
                rdat_q <= op_q.we ? '0 : DATA_W'(sel_bit);
            end
        end
    end

    assign m_addr  = op_q.addr;
    assign m_size  = op_q.size;
    assign m_wdata = wbuf;
    assign s_rdata = rdat_q;
endmodule

// File: rtl/bitalias_checker.sv
module bitalias_checker (
    input logic        clk,
    input logic        rst,
    input logic        s_ready,
    input logic [31:0] s_rdata,
    input logic        m_req,
    input logic        m_we,
    input logic        m_lock,
    input logic        m_ready,
    input logic [31:0] m_addr,
    input logic [1:0]  m_size
);
    // R1
    idle_after_reset_chk: assert property (@(posedge clk)
        $fell(rst) |-> !s_ready && !m_req && !m_lock);

    // R2
    word_align_chk: assert property (@(posedge clk) disable iff (rst)
        (m_req && m_size == 2'd2) |-> m_addr[1:0] == 2'b00);

    // R2
    half_align_chk: assert property (@(posedge clk) disable iff (rst)
        (m_req && m_size == 2'd1) |-> !m_addr[0]);

    // R4
    rdata_single_bit_chk: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> s_rdata[31:1] == 31'd0);

    // R5
    unlocked_is_read_chk: assert property (@(posedge clk) disable iff (rst)
        (m_req && !m_lock) |-> !m_we);

    // R8
    write_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (m_req && m_we) |-> m_lock);

    // R8
    locked_read_then_write_chk: assert property (@(posedge clk) disable iff (rst)
        (m_req && !m_we && m_lock && m_ready) |=> (m_req && m_we && m_lock));

    // R10
    req_held_chk: assert property (@(posedge clk) disable iff (rst)
        (m_req && !m_ready) |=> (m_req && $stable(m_addr) && $stable(m_we)));

    // R10
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        s_ready |=> !s_ready);

    // R10
    no_resp_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> !m_req);
endmodule

bind bitalias_bridge bitalias_checker u_bitalias_checker (
    .clk     (clk),
    .rst     (rst),
    .s_ready (s_ready),
    .s_rdata (s_rdata),
    .m_req   (m_req),
    .m_we    (m_we),
    .m_lock  (m_lock),
    .m_ready (m_ready),
    .m_addr  (m_addr),
    .m_size  (m_size)
);

// File: tb/bitalias_bridge_bench.sv
module bitalias_bridge_bench;
    localparam logic [31:0] BASE = 32'h2000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        s_req = 1'b0, s_we = 1'b0;
    logic [1:0]  s_size = 2'd0;
    logic [31:0] s_addr = '0, s_wdata = '0;
    logic        s_ready;
    logic [31:0] s_rdata;
    logic        m_req, m_we, m_lock;
    logic [1:0]  m_size;
    logic [31:0] m_addr, m_wdata;
    logic        m_ready = 1'b0;
    logic [31:0] m_rdata = '0;

    always #2 clk = ~clk;

    bitalias_bridge #(.BASE(BASE)) u_bitalias_bridge (
        .clk(clk), .rst(rst), .s_req(s_req), .s_we(s_we), .s_size(s_size),
        .s_addr(s_addr), .s_wdata(s_wdata), .s_ready(s_ready), .s_rdata(s_rdata),
        .m_req(m_req), .m_we(m_we), .m_lock(m_lock), .m_size(m_size),
        .m_addr(m_addr), .m_wdata(m_wdata), .m_ready(m_ready), .m_rdata(m_rdata)
    );

    logic [7:0]  mem    [256];
    logic [7:0]  shadow [256];
    int          checks = 0, fails = 0;
    int          lat = 0, nrd = 0, nwr = 0;
    logic [31:0] exp_addr = '0;
    logic [1:0]  exp_size = '0;
    logic        exp_we = 1'b0;
    bit          done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // backing memory responder
    initial begin
        forever begin
            @(negedge clk);
            m_ready = 1'b0;
            if (m_req && !rst) begin
                logic [31:0] a0;
                logic [7:0]  b;
                a0 = m_addr;
                repeat (lat) @(negedge clk);
                chk(m_req && m_addr == a0, "R10 request held", m_addr, a0);
                chk(m_addr == exp_addr, "R2 backing address", m_addr, exp_addr);
                chk(m_size == exp_size, "R2 backing size", 32'(m_size), 32'(exp_size));
                b = m_addr[7:0];
                if (m_we) begin
                    nwr++;
                    chk(m_lock, "R8 lock on store", 32'(m_lock), 32'd1);
                    chk(nrd == 1, "R6 fetch before store", nrd, 32'd1);
                    for (int j = 0; j < (1 << m_size); j++)
                        mem[b + 8'(j)] = m_wdata[8*j +: 8];
                end else begin
                    nrd++;
                    chk(m_lock == exp_we, "R5 R8 lock on fetch", 32'(m_lock), 32'(exp_we));
                    // R9: little-endian, always four bytes
                    m_rdata = {mem[b + 8'd3], mem[b + 8'd2], mem[b + 8'd1], mem[b]};
                end
                m_ready = 1'b1;
            end
        end
    end

    task automatic alias_op(input bit we, input int sz, input int b, input int k, input bit val);
        logic [24:0] off;
        int          n;
        logic        expbit;
        case (sz)
            0:       off = 25'(b << 5) | 25'(k << 2);
            1:       off = 25'((b >> 1) << 6) | 25'(k << 2);
            default: off = 25'((b >> 2) << 7) | 25'(k << 2);
        endcase
        exp_addr = BASE + 32'(b);
        exp_size = 2'(sz);
        exp_we   = we;
        nrd = 0;
        nwr = 0;
        @(negedge clk);
        s_req   = 1'b1;
        s_we    = we;
        s_size  = 2'(sz);
        s_addr  = {7'($urandom), off | 25'($urandom & 3)};
        s_wdata = val ? ($urandom | 32'd1) : ($urandom & ~32'd1);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!s_ready && n < 50);
        chk(s_ready, "R10 response arrives", 32'(s_ready), 32'd1);
        if (we) begin
            chk(nrd == 1 && nwr == 1, "R6 one fetch and one store", 32'(nrd * 16 + nwr), 32'h11);
            shadow[b + k / 8][k % 8] = val;
        end else begin
            expbit = shadow[b + k / 8][k % 8];
            chk(nrd == 1 && nwr == 0, "R5 single fetch", 32'(nrd * 16 + nwr), 32'h10);
            chk(s_rdata == 32'(expbit), "R3 R4 read bit", s_rdata, 32'(expbit));
        end
        s_req = 1'b0;
        @(negedge clk);
        chk(!s_ready, "R10 one-cycle response", 32'(s_ready), 32'd0);
        if (we) begin
            int bad;
            bad = -1;
            for (int i = 0; i < 256; i++)
                if (mem[i] != shadow[i] && bad < 0) bad = i;
            chk(bad < 0, "R6 R7 R9 backing contents",
                bad < 0 ? 32'd0 : 32'(mem[bad]), bad < 0 ? 32'd0 : 32'(shadow[bad]));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]    = 8'($urandom);
            shadow[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!s_ready && !m_req && !m_lock, "R1 reset state",
            {29'd0, s_ready, m_req, m_lock}, 32'd0);
        for (int sz = 0; sz < 3; sz++) begin
            for (int u = 0; u < 8; u++) begin
                int b;
                b = (sz == 0) ? u * 31 : (sz == 1) ? u * 30 : u * 32;
                for (int k = 0; k < (8 << sz); k++) begin
                    lat = (k + u) % 3;
                    alias_op(1'b0, sz, b, k, 1'b0);
                    alias_op(1'b1, sz, b, k, 1'($urandom));
                    alias_op(1'b0, sz, b, k, 1'b0);
                end
            end
        end
        finish_run();
    end
endmodule